// File: doc/BRIEF.md
# Contention-Free Interleaved Bank Crossbar

This block sits between N parallel soft-output decoders and N extrinsic-message memory banks in an iterative decoder. A frame of K = N*L symbols is cut into N equal segments of length L, and decoder j works on symbols jL through jL+L-1. All decoders step through their segments together, so in any access cycle they share one local step index k and decoder j touches global symbol jL+k.

For each decoder, the block looks up that global symbol in a loadable permutation table. In the deinterleave direction it uses a second, inverse table. It splits the permuted address into a bank number (upper bits, the address divided by L) and an in-bank offset (lower bits, the address modulo L). The write payload then goes through a fully connected crossbar to the selected bank. When the N accesses land on N distinct banks, every bank receives exactly one write. When two or more decoders pick the same bank, those decoders' writes are dropped for that cycle, a per-cycle clash pulse is raised, and a sticky clash flag is set. N and L must be powers of two, and N must be at least 2.

Both tables are loaded one entry per cycle through a simple write port before decoding starts. On reset both tables return to the identity mapping, so decoder j writes bank j at offset k.

Top module: `ilv_bank_xbar`

## Requirements
- R1: After reset, `bank_we`, `clash_now` and `clash_sticky` are 0 and both tables hold the identity (entry x = x).
- R2: With identity tables, a request at step k writes decoder j's payload into bank j at offset k.
- R3: With `dir_inv`=0, decoder j uses forward entry p = fwd[jL+k]. Bank p/L (address bits [AW-1:log2 L]) is written with offset p mod L (low log2 L bits) and decoder j's payload. A request with no shared bank writes all N banks and leaves `clash_now` at 0.
- R4: With `dir_inv`=1, the same routing uses the inverse table entry inv[jL+k].
- R5: Bank writes appear exactly one clock after the request cycle. A cycle without `req_valid` produces no bank write and no clash pulse.
- R6: Decoders whose bank is also chosen by another decoder in the same cycle have their writes suppressed. Decoders on unshared banks are still written. `clash_now` is 1 in the following cycle.
- R7: `clash_sticky` becomes 1 together with any `clash_now` pulse and stays 1 until reset.
- R8: `tbl_we`=1 writes `tbl_data` into entry `tbl_addr` of the forward table (`tbl_sel`=0) or the inverse table (`tbl_sel`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_sel | input | 1 | 0 selects the forward table, 1 the inverse table |
| tbl_addr | input | AW | Entry index, AW = log2(N*L) |
| tbl_data | input | AW | Permuted address stored in the entry |
| req_valid | input | 1 | Access cycle strobe |
| dir_inv | input | 1 | 0 interleave (forward table), 1 deinterleave (inverse table) |
| step | input | log2 L | Shared local step index k |
| wr_data | input | N*DW | Payload of decoder j in bits [j*DW +: DW] |
| bank_we | output | N | Write enable of each bank |
| bank_addr | output | N*log2 L | Offset for bank b in bits [b*log2L +: log2L] |
| bank_data | output | N*DW | Data for bank b in bits [b*DW +: DW] |
| clash_now | output | 1 | Bank clash in the previous access cycle |
| clash_sticky | output | 1 | Clash seen since reset |

## Verification
In one access cycle, clean routing and clash suppression can happen together: some decoders share a bank while others do not. The bench provokes this by patching table entries so that two decoders, or all four, aim at the same bank while the rest stay on distinct banks. It then compares every bank's enable, offset and data, plus the clash pulse, against a model that counts hits per bank. Table loading and deinterleave routing are also judged in the same run, against an independently computed quadratic permutation and its inverse.

// File: rtl/ilv_bank_xbar.sv
module ilv_bank_xbar #(
  parameter int NDEC = 4,
  parameter int SEG  = 16,
  parameter int DW   = 8,
  localparam int K   = NDEC * SEG,
  localparam int AW  = $clog2(K),
  localparam int BW  = $clog2(NDEC),
  localparam int OW  = $clog2(SEG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tbl_we,
  input  logic                 tbl_sel,
  input  logic [AW-1:0]        tbl_addr,
  input  logic [AW-1:0]        tbl_data,
  input  logic                 req_valid,
  input  logic                 dir_inv,
  input  logic [OW-1:0]        step,
  input  logic [NDEC*DW-1:0]   wr_data,
  output logic [NDEC-1:0]      bank_we,
  output logic [NDEC*OW-1:0]   bank_addr,
  output logic [NDEC*DW-1:0]   bank_data,
  output logic                 clash_now,
  output logic                 clash_sticky
);

  logic [AW-1:0] fwd_tbl [K];
  logic [AW-1:0] inv_tbl [K];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < K; i++) begin
        fwd_tbl[i] <= AW'(i);
        inv_tbl[i] <= AW'(i);
      end
    end else if (tbl_we) begin
      if (tbl_sel) inv_tbl[tbl_addr] <= tbl_data;
      else         fwd_tbl[tbl_addr] <= tbl_data;
    end
  end

  logic [BW-1:0] bank_of [NDEC];
  logic [OW-1:0] off_of  [NDEC];

  for (genvar j = 0; j < NDEC; j++) begin : g_look
    logic [AW-1:0] gaddr, perm;
    assign gaddr      = {BW'(j), step};
    assign perm       = dir_inv ? inv_tbl[gaddr] : fwd_tbl[gaddr];
    assign bank_of[j] = perm[AW-1:OW];
    assign off_of[j]  = perm[OW-1:0];
  end

  logic [NDEC-1:0] hit;
  always_comb begin
    hit = '0;
    for (int j = 0; j < NDEC; j++)
      for (int i = 0; i < NDEC; i++)
        if (i != j && bank_of[i] == bank_of[j]) hit[j] = 1'b1;
  end

  logic [NDEC-1:0]    nx_we;
  logic [NDEC*OW-1:0] nx_addr;
  logic [NDEC*DW-1:0] nx_data;
  logic               nx_clash;

  assign nx_clash = req_valid && (|hit);

  always_comb begin
    nx_we   = '0;
    nx_addr = '0;
    nx_data = '0;
    for (int b = 0; b < NDEC; b++)
      for (int j = 0; j < NDEC; j++)
        if (req_valid && !hit[j] && bank_of[j] == BW'(b)) begin
          nx_we[b]              = 1'b1;
          nx_addr[b*OW +: OW]   = off_of[j];
          nx_data[b*DW +: DW]   = wr_data[j*DW +: DW];
        end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_we      <= '0;
      bank_addr    <= '0;
      bank_data    <= '0;
      clash_now    <= 1'b0;
      clash_sticky <= 1'b0;
    end else begin
      bank_we      <= nx_we;
      bank_addr    <= nx_addr;
      bank_data    <= nx_data;
      clash_now    <= nx_clash;
      clash_sticky <= clash_sticky | nx_clash;
    end
  end

endmodule

// File: rtl/ilv_bank_xbar_chk.sv
module ilv_bank_xbar_chk #(
  parameter int NDEC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [NDEC-1:0] bank_we,
  input logic            clash_now,
  input logic            clash_sticky
);

  p_idle_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> bank_we == '0);

  p_idle_no_clash_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !clash_now);

  p_full_when_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (clash_now || (&bank_we)));

  p_clash_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clash_now |-> ($countones(bank_we) <= NDEC - 2));

  p_sticky_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clash_now |-> clash_sticky);

  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clash_sticky |=> clash_sticky);

endmodule

bind ilv_bank_xbar ilv_bank_xbar_chk #(.NDEC(NDEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bank_we(bank_we),
  .clash_now(clash_now), .clash_sticky(clash_sticky)
);

// File: tb/ilv_bank_xbar_tb.sv
module ilv_bank_xbar_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NDEC = 4;
  localparam int SEG  = 16;
  localparam int DW   = 8;
  localparam int K    = NDEC * SEG;
  localparam int AW   = $clog2(K);
  localparam int OW   = $clog2(SEG);

  logic clk = 0, rst_n = 0;
  logic tbl_we = 0, tbl_sel = 0;
  logic [AW-1:0] tbl_addr = '0, tbl_data = '0;
  logic req_valid = 0, dir_inv = 0;
  logic [OW-1:0] step = '0;
  logic [NDEC*DW-1:0] wr_data = '0;
  logic [NDEC-1:0] bank_we;
  logic [NDEC*OW-1:0] bank_addr;
  logic [NDEC*DW-1:0] bank_data;
  logic clash_now, clash_sticky;

  ilv_bank_xbar #(.NDEC(NDEC), .SEG(SEG), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .req_valid(req_valid),
    .dir_inv(dir_inv), .step(step), .wr_data(wr_data), .bank_we(bank_we),
    .bank_addr(bank_addr), .bank_data(bank_data), .clash_now(clash_now),
    .clash_sticky(clash_sticky)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [NDEC-1:0]    we;
    logic [NDEC*OW-1:0] addr;
    logic [NDEC*DW-1:0] data;
    logic               clash;
    string              tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0;
  int mfwd [K];
  int minv [K];

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_entry(bit sel, int a, int d);
    @(negedge clk);
    tbl_we = 1; tbl_sel = sel; tbl_addr = AW'(a); tbl_data = AW'(d);
    if (sel) minv[a] = d; else mfwd[a] = d;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic send(bit dir, int k, string tag);
    exp_t e;
    int cnt [NDEC];
    int p [NDEC];
    @(negedge clk);
    req_valid = 1; dir_inv = dir; step = OW'(k);
    for (int j = 0; j < NDEC; j++)
      wr_data[j*DW +: DW] = DW'(j*37 + k*5 + (dir ? 101 : 0));
    for (int b = 0; b < NDEC; b++) cnt[b] = 0;
    for (int j = 0; j < NDEC; j++) begin
      p[j] = dir ? minv[j*SEG + k] : mfwd[j*SEG + k];
      cnt[p[j] / SEG]++;
    end
    e.we = '0; e.addr = '0; e.data = '0; e.clash = 0; e.tag = tag;
    for (int j = 0; j < NDEC; j++) begin
      int b = p[j] / SEG;
      if (cnt[b] == 1) begin
        e.we[b] = 1;
        e.addr[b*OW +: OW] = OW'(p[j] % SEG);
        e.data[b*DW +: DW] = wr_data[j*DW +: DW];
      end else e.clash = 1;
    end
    exp_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && req_valid) begin
        exp_t e;
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check("scoreboard underflow", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check({e.tag, " bank_we"},   64'(bank_we),   64'(e.we));
          check({e.tag, " bank_addr"}, 64'(bank_addr), 64'(e.addr));
          check({e.tag, " bank_data"}, 64'(bank_data), 64'(e.data));
          check({e.tag, " clash_now"}, 64'(clash_now), 64'(e.clash));
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int x = 0; x < K; x++) begin mfwd[x] = x; minv[x] = x; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 bank_we after reset", 64'(bank_we), 0);
    check("R1 clash_now after reset", 64'(clash_now), 0);
    check("R1 clash_sticky after reset", 64'(clash_sticky), 0);

    send(0, 0, "R2 identity k0");
    send(0, 5, "R2 identity k5");
    send(0, 15, "R2 identity k15");
    send(1, 7, "R2 identity inverse k7");
    idle();
    @(negedge clk);
    check("R5 no write when idle", 64'(bank_we), 0);

    for (int x = 0; x < K; x++) load_entry(0, x, (5*x + 8*x*x) % K);
    for (int x = 0; x < K; x++) load_entry(1, (5*x + 8*x*x) % K, x);

    for (int k = 0; k < SEG; k++) send(0, k, "R3 R8 forward qpp");
    for (int k = 0; k < SEG; k++) send(1, k, "R4 R8 inverse qpp");
    idle();
    @(negedge clk);
    check("R5 idle after burst", 64'(bank_we), 0);
    check("R3 no sticky after clean tables", 64'(clash_sticky), 0);

    load_entry(0, 3, 20);
    load_entry(0, 19, 21);
    load_entry(0, 9, 32);
    load_entry(0, 25, 33);
    load_entry(0, 41, 34);
    load_entry(0, 57, 35);
    send(0, 3, "R6 partial clash");
    idle();
    @(negedge clk);
    check("R7 sticky after clash", 64'(clash_sticky), 1);
    send(0, 9, "R6 full clash");
    send(0, 4, "R6 clean after clash");
    idle();
    repeat (2) @(negedge clk);
    check("R7 sticky holds", 64'(clash_sticky), 1);
    check("R5 no pulse when idle", 64'(clash_now), 0);

    rst_n = 0;
    for (int x = 0; x < K; x++) begin mfwd[x] = x; minv[x] = x; end
    @(negedge clk);
    check("R1 sticky cleared by reset", 64'(clash_sticky), 0);
    rst_n = 1;
    send(0, 9, "R1 identity restored");
    send(1, 3, "R1 inverse identity restored");
    idle();
    repeat (2) @(negedge clk);
    check("scoreboard drained", 64'(exp_q.size()), 0);
    finish_run();
  end
endmodule